// File: doc/BRIEF.md
# Five-Source Bus Master Arbiter

This block decides which of five requesters may open the next master transaction on a shared bus. Four of the requesters are DMA channels: transmit 0 (T0), transmit 1 (T1), receive 0 (R0) and receive 1 (R1). The fifth is a single-access requester that issues one-off transfers without going through the channel queues. A 2-bit mode input chooses how the DMA channels are ranked against each other. The single-access requester outranks all of them in every mode.

There are three ranking methods. Round robin rotates through the channels. Prioritized mode compares a 2-bit priority value per channel. Custom mode hands the decision to outside logic: the block exports the pending channel requests and takes back an encoded selection.

The grant is registered and one-hot. It stays in place until the granted master pulses done. The arbiter then spends one idle cycle and arbitrates again. Requests are looked at only while no grant is held.

Top module: `bus_master_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `grant_o` is 0 and `busy_o` is 0.
- R2: Whenever the arbiter is idle and `single_req_i` is 1, the next grant is the single-access bit (`grant_o` = 5'b10000), in every mode and whatever the channel requests are. The `grant_o` encoding is: bit 0 = T0, bit 1 = T1, bit 2 = R0, bit 3 = R1, bit 4 = single access.
- R3: `grant_o` has at most one bit set. A grant stays unchanged until `done_i` is seen high while the grant is held. `grant_o` is 0 in the cycle after that. A `done_i` pulse while idle has no effect.
- R4: Request, mode, priority and select inputs are sampled only while idle. Changes to them while a grant is held do not alter the grant.
- R5: In mode 00 (round robin), the search starts at the channel after the one last granted and follows the order T0, T1, R0, R1 with wraparound. Channels that are not requesting are skipped. A channel grant in any mode counts as the last grant. After reset the search starts at T0. `req_i` encoding: bit 0 = T0, bit 1 = T1, bit 2 = R0, bit 3 = R1.
- R6: In mode 01 (prioritized), the requesting channel with the numerically highest priority wins. Channel c's priority is `prio_i[2c+1:2c]`.
- R7: In mode 01, ties between requesting channels of equal priority are broken in the order T0, T1, R0, R1 (highest first).
- R8: In mode 10 (custom), `ext_req_o` shows the pending channel requests with bit 0 = R1, bit 1 = R0, bit 2 = T1, bit 3 = T0. In every other mode `ext_req_o` is 0.
- R9: In mode 10, `ext_sel_i` picks the grant with 00 = R1, 01 = R0, 10 = T1 and 11 = T0. If the selected channel is not requesting, no grant is issued.
- R10: Mode 11 (reserved) arbitrates exactly like round robin and shares its rotation state.
- R11: A grant appears on `grant_o` one clock edge after the idle cycle in which the requests were sampled. `busy_o` is 1 exactly while a grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Arbitration mode (00 round robin, 01 prioritized, 10 custom, 11 reserved) |
| req_i | input | 4 | Channel requests, bit 0 T0 to bit 3 R1 |
| single_req_i | input | 1 | Single-access request |
| prio_i | input | 8 | 2-bit priority per channel, channel c at [2c+1:2c] |
| ext_sel_i | input | 2 | External grant selection in custom mode |
| done_i | input | 1 | Completion pulse from the granted master |
| ext_req_o | output | 4 | Exported requests in custom mode, bit 0 R1 to bit 3 T0 |
| grant_o | output | 5 | One-hot grant, bit 4 single access |
| busy_o | output | 1 | A grant is held |

## Verification
Two functions can fall in the same cycle. The single-access override can coincide with any channel pick. A completion pulse can coincide with requests that change while a grant is held.

The bench drives single-access requests together with full channel request sets in the round robin, prioritized and custom modes. It expects the single-access bit each time, and it expects the rotation state to be left where it was.

In a directed sequence, the bench changes requests and asserts single access while a channel holds the grant, and then raises done. The grant must stay put, then give way to exactly one idle cycle, and only then go to the single-access requester. A done pulse held through an idle cycle must not prevent the next grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        MODE_RR   = 2'b00,
        MODE_PRIO = 2'b01,
        MODE_CUST = 2'b10,
        MODE_RSVD = 2'b11
    } arb_mode_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IDX_W-1:0]  last,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int off = 1; off <= NUM_CH; off++) begin
            int cand;
            cand = (int'(last) + off) % NUM_CH;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 2,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio,
    output logic                     found,
    output logic [IDX_W-1:0]         idx
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (req[c] && (!found || prio[c*PRIO_W +: PRIO_W] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(c);
                best  = prio[c*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/arb_custom_pick.sv
module arb_custom_pick #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              enable,
    input  logic [NUM_CH-1:0] req,
    input  logic [IDX_W-1:0]  sel,
    output logic [NUM_CH-1:0] ext_req,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    genvar k;
    generate
        for (k = 0; k < NUM_CH; k++) begin : g_export
            assign ext_req[k] = enable & req[NUM_CH-1-k];
        end
    endgenerate

    assign idx   = IDX_W'(NUM_CH - 1 - int'(sel));
    assign found = req[idx];
endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 2,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int GNT_W = NUM_CH + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic                     single_req_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]         ext_sel_i,
    input  logic                     done_i,
    output logic [NUM_CH-1:0]        ext_req_o,
    output logic [GNT_W-1:0]         grant_o,
    output logic                     busy_o
);
    typedef struct packed {
        logic [GNT_W-1:0] grant;
        logic [IDX_W-1:0] last;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic             rr_found, pr_found, cu_found;
    logic [IDX_W-1:0] rr_idx, pr_idx, cu_idx;
    arb_mode_e        mode;

    assign mode = arb_mode_e'(mode_i);

    arb_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
        .req   (req_i),
        .last  (state_q.last),
        .found (rr_found),
        .idx   (rr_idx)
    );

    arb_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_prio (
        .req   (req_i),
        .prio  (prio_i),
        .found (pr_found),
        .idx   (pr_idx)
    );

    arb_custom_pick #(.NUM_CH(NUM_CH)) u_cust (
        .enable  (mode == MODE_CUST),
        .req     (req_i),
        .sel     (ext_sel_i),
        .ext_req (ext_req_o),
        .found   (cu_found),
        .idx     (cu_idx)
    );

    always_comb begin
        logic             hit;
        logic [IDX_W-1:0] pick;
        state_d = state_q;
        hit     = 1'b0;
        pick    = '0;
        unique case (mode)
            MODE_PRIO: begin hit = pr_found; pick = pr_idx; end
            MODE_CUST: begin hit = cu_found; pick = cu_idx; end
            default:   begin hit = rr_found; pick = rr_idx; end
        endcase
        if (state_q.grant != '0) begin
            if (done_i) begin
                state_d.grant = '0;
            end
        end else if (single_req_i) begin
            state_d.grant = GNT_W'(1) << NUM_CH;
        end else if (hit) begin
            state_d.grant = GNT_W'(1) << pick;
            state_d.last  = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.grant <= '0;
            state_q.last  <= IDX_W'(NUM_CH - 1);
        end else begin
            state_q <= state_d;
        end
    end

    assign grant_o = state_q.grant;
    assign busy_o  = |state_q.grant;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 2,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int GNT_W = NUM_CH + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               mode_i,
    input logic [NUM_CH-1:0]        req_i,
    input logic                     single_req_i,
    input logic [NUM_CH*PRIO_W-1:0] prio_i,
    input logic [IDX_W-1:0]         ext_sel_i,
    input logic                     done_i,
    input logic [NUM_CH-1:0]        ext_req_o,
    input logic [GNT_W-1:0]         grant_o,
    input logic                     busy_o
);
    logic idle;
    logic sel_hit;

    assign idle    = (grant_o == '0);
    assign sel_hit = req_i[IDX_W'(NUM_CH - 1 - int'(ext_sel_i))];

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R3
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !done_i) |=> $stable(grant_o));

    // R3
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && done_i) |=> (grant_o == '0));

    // R2
    single_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && single_req_i) |=> (grant_o == (GNT_W'(1) << NUM_CH)));

    // R8
    export_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b10) |-> (ext_req_o == '0));

    // R9
    custom_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && mode_i == 2'b10 && !single_req_i && !sel_hit) |=> (grant_o == '0));

    // R11
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (grant_o != '0));
endmodule

bind bus_master_arbiter arb_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_arb_chk (.*);

// File: tb/tb_bus_master_arbiter.sv
module tb_bus_master_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = '0;
    logic [3:0] req_i = '0;
    logic       single_req_i = 1'b0;
    logic [7:0] prio_i = '0;
    logic [1:0] ext_sel_i = '0;
    logic       done_i = 1'b0;
    logic [3:0] ext_req_o;
    logic [4:0] grant_o;
    logic       busy_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bus_master_arbiter dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // {mode, req(R1 R0 T1 T0), single, prio, sel, exp_grant, exp_ext}
    localparam logic [25:0] VECS [NV] = '{
        {2'b00, 4'b1111, 1'b0, 8'h00, 2'b00, 5'b00001, 4'b0000}, // R5 start at T0
        {2'b00, 4'b1111, 1'b0, 8'h00, 2'b00, 5'b00010, 4'b0000}, // R5
        {2'b00, 4'b1111, 1'b0, 8'h00, 2'b00, 5'b00100, 4'b0000}, // R5
        {2'b00, 4'b1111, 1'b0, 8'h00, 2'b00, 5'b01000, 4'b0000}, // R5
        {2'b00, 4'b0101, 1'b0, 8'h00, 2'b00, 5'b00001, 4'b0000}, // R5 wrap
        {2'b00, 4'b0101, 1'b0, 8'h00, 2'b00, 5'b00100, 4'b0000}, // R5 skip T1
        {2'b00, 4'b0010, 1'b0, 8'h00, 2'b00, 5'b00010, 4'b0000}, // R5
        {2'b11, 4'b1111, 1'b0, 8'h00, 2'b00, 5'b00100, 4'b0000}, // R10
        {2'b00, 4'b1111, 1'b1, 8'h00, 2'b00, 5'b10000, 4'b0000}, // R2
        {2'b01, 4'b1111, 1'b0, 8'hB4, 2'b00, 5'b00100, 4'b0000}, // R6
        {2'b01, 4'b1111, 1'b0, 8'h55, 2'b00, 5'b00001, 4'b0000}, // R7
        {2'b01, 4'b1110, 1'b0, 8'h55, 2'b00, 5'b00010, 4'b0000}, // R7
        {2'b01, 4'b1100, 1'b0, 8'hF0, 2'b00, 5'b00100, 4'b0000}, // R7
        {2'b01, 4'b1001, 1'b0, 8'h40, 2'b00, 5'b01000, 4'b0000}, // R6
        {2'b01, 4'b1111, 1'b1, 8'hFF, 2'b00, 5'b10000, 4'b0000}, // R2
        {2'b10, 4'b1111, 1'b0, 8'h00, 2'b00, 5'b01000, 4'b1111}, // R9
        {2'b10, 4'b0001, 1'b0, 8'h00, 2'b11, 5'b00001, 4'b1000}, // R8 R9
        {2'b10, 4'b0010, 1'b0, 8'h00, 2'b10, 5'b00010, 4'b0100}, // R8 R9
        {2'b10, 4'b0100, 1'b0, 8'h00, 2'b01, 5'b00100, 4'b0010}, // R8 R9
        {2'b10, 4'b0100, 1'b0, 8'h00, 2'b00, 5'b00000, 4'b0010}, // R9 miss
        {2'b10, 4'b0000, 1'b1, 8'h00, 2'b11, 5'b10000, 4'b0000}, // R2
        {2'b00, 4'b1111, 1'b0, 8'h00, 2'b00, 5'b01000, 4'b0000}, // R5 after R0
        {2'b00, 4'b0000, 1'b0, 8'h00, 2'b00, 5'b00000, 4'b0000}  // R5 none
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        check("R1 grant in reset", {3'b0, grant_o}, 8'h00);
        check("R1 busy in reset", {7'b0, busy_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grant after reset", {3'b0, grant_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VECS[i];
            mode_i       = v[25:24];
            req_i        = v[23:20];
            single_req_i = v[19];
            prio_i       = v[18:11];
            ext_sel_i    = v[10:9];
            done_i       = 1'b0;
            @(negedge clk);
            check($sformatf("R11 vector %0d grant", i), {3'b0, grant_o}, {3'b0, v[8:4]});
            check($sformatf("R8 vector %0d export", i), {4'b0, ext_req_o}, {4'b0, v[3:0]});
            if (v[8:4] != '0) begin
                done_i = 1'b1;
                req_i = '0;
                single_req_i = 1'b0;
                @(negedge clk);
                done_i = 1'b0;
                check($sformatf("R3 vector %0d release", i), {3'b0, grant_o}, 8'h00);
            end else begin
                req_i = '0;
                single_req_i = 1'b0;
            end
        end

        // R4: inputs change while T0 holds the grant
        mode_i = 2'b00;
        req_i = 4'b0001;
        @(negedge clk);
        check("R4 initial T0", {3'b0, grant_o}, 8'h01);
        req_i = 4'b1110;
        single_req_i = 1'b1;
        mode_i = 2'b01;
        prio_i = 8'hFC;
        @(negedge clk);
        check("R4 hold 1", {3'b0, grant_o}, 8'h01);
        @(negedge clk);
        check("R4 hold 2", {3'b0, grant_o}, 8'h01);
        check("R11 busy held", {7'b0, busy_o}, 8'h01);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        check("R3 idle cycle after done", {3'b0, grant_o}, 8'h00);
        check("R11 busy idle", {7'b0, busy_o}, 8'h00);
        @(negedge clk);
        check("R2 single after release", {3'b0, grant_o}, 8'h10);

        // R3: done while idle is ignored
        single_req_i = 1'b0;
        req_i = 4'b0010;
        done_i = 1'b1;
        @(negedge clk);
        check("R3 released single", {3'b0, grant_o}, 8'h00);
        @(negedge clk);
        check("R3 done while idle ignored", {3'b0, grant_o}, 8'h02);
        check("R11 busy on grant", {7'b0, busy_o}, 8'h01);
        done_i = 1'b0;
        req_i = '0;
        @(negedge clk);
        check("R3 stays without done", {3'b0, grant_o}, 8'h02);

        summary();
    end
endmodule